// File: doc/BRIEF.md
# Program Counter and Return-Address Sequencer

This block holds the program counter of a small 8-bit controller whose instructions live in a 12-bit address space. In every cycle the decoder gives it an operation code, a condition selector, a target address, the live carry and zero flags and an interrupt request. The block then chooses the next address. It can step, jump, call or return. It can also enter an interrupt or leave one.

Return addresses are kept in an internal last-in-first-out stack with 31 entries. When an interrupt is accepted, the block saves the carry and zero flags into preserved copies and drives those copies on its outputs. It also gives a one-cycle restore strobe, which the flag logic uses when an interrupt return puts them back. The interrupt-enable bit is held here too. A push onto a full stack or a pop from an empty stack sets a sticky error output.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is held and in the first cycles after it, pc_o is 0x000, int_en_o is 0, stack_err_o is 0 and the stack is empty.
- R2: Operation code 0 (and the unused codes 8 to 15) moves pc_o to pc_o+1 on the next cycle. 0xFFF steps to 0x000.
- R3: Operation code 1 (jump) loads target_i when the condition holds and otherwise steps by one. The condition is selected by cond_i: bit 2 clear means always. With bit 2 set, bit 1 chooses carry (1) or zero (0), and bit 0 set inverts the test. So 4 is Z, 5 is NZ, 6 is C and 7 is NC.
- R4: Operation code 2 (call) with a true condition pushes the current pc_o and loads target_i. With a false condition it steps by one.
- R5: Operation code 3 (return) with a true condition pops the top entry and loads that entry plus one. With a false condition it steps by one and leaves the stack alone.
- R6: Operation codes 4 and 5 (interrupt return) ignore cond_i. They pop the top entry and load it unchanged. In the same cycle they pulse restore_o, and they set int_en_o to 1 for code 4 or to 0 for code 5.
- R7: Operation codes 6 and 7 set and clear int_en_o respectively. The PC steps by one and nothing else changes.
- R8: When irq_i is high while int_en_o is 1, the operation is discarded. The current pc_o is pushed, carry_i and zero_i are copied to carry_o and zero_o, int_en_o clears and pc_o becomes 0xFFF. With int_en_o at 0, irq_i has no effect.
- R9: The stack holds 31 entries. A call on a full stack sets stack_err_o, pushes nothing and steps by one. An accepted interrupt on a full stack sets stack_err_o, pushes nothing and still vectors to 0xFFF.
- R10: A return or interrupt return with a true condition on an empty stack sets stack_err_o and steps by one. int_en_o, carry_o and zero_o stay unchanged and restore_o stays low.
- R11: Once set, stack_err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| op_i | input | 4 | Decoded operation code |
| cond_i | input | 3 | Condition selector |
| target_i | input | 12 | Jump or call target address |
| carry_i | input | 1 | Live carry flag |
| zero_i | input | 1 | Live zero flag |
| irq_i | input | 1 | Interrupt request |
| pc_o | output | 12 | Current program counter |
| carry_o | output | 1 | Preserved carry copy |
| zero_o | output | 1 | Preserved zero copy |
| restore_o | output | 1 | Strobe: preserved flags are to be written back this cycle |
| int_en_o | output | 1 | Interrupt enable |
| stack_err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
Most internal faults in this block stay hidden until a return is executed. A wrong stack pointer or a corrupted entry sends pc_o to the wrong address in the cycle after that return. A wrong capacity boundary shows up as stack_err_o rising one call too early, or not at all, as the stack fills. Errors in the preserved flags or the enable bit appear only at the interrupt entry or return that uses them. For that reason the stimulus nests calls, fills and drains the stack completely, and mixes interrupts in between calls. The reference model compares every output in every cycle, so a fault is caught in the first cycle it reaches a port.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [3:0] {
    OP_NEXT     = 4'd0,
    OP_JUMP     = 4'd1,
    OP_CALL     = 4'd2,
    OP_RET      = 4'd3,
    OP_RETI_EN  = 4'd4,
    OP_RETI_DIS = 4'd5,
    OP_EI       = 4'd6,
    OP_DI       = 4'd7
  } op_e;
endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond (
  input  logic [2:0] sel_i,
  input  logic       carry_i,
  input  logic       zero_i,
  output logic       hit_o
);
  logic flag;
  always_comb begin
    flag  = sel_i[1] ? carry_i : zero_i;
    hit_o = !sel_i[2] || (flag ^ sel_i[0]);
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int AW    = 12,
  parameter int DEPTH = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] top_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d;
  logic          err_q, err_d;
  logic [PW-1:0] top_idx;
  logic          do_push, do_pop;

  always_comb begin
    full_o  = (ptr_q == PW'(DEPTH));
    empty_o = (ptr_q == '0);
    top_idx = empty_o ? '0 : ptr_q - PW'(1);
    top_o   = mem[top_idx];
    do_push = push_i && !full_o;
    do_pop  = pop_i && !empty_o;
    ptr_d   = ptr_q;
    if (do_push)     ptr_d = ptr_q + PW'(1);
    else if (do_pop) ptr_d = ptr_q - PW'(1);
    err_d = err_q || (push_i && full_o) || (pop_i && empty_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      err_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      err_q <= err_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic wen;
    assign wen = do_push && (ptr_q == PW'(gi));
    always_ff @(posedge clk) begin
      if (wen) mem[gi] <= wdata_i;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int          AW     = 12,
  parameter int          DEPTH  = 31,
  parameter logic [11:0] VECTOR = 12'hFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic [2:0]    cond_i,
  input  logic [AW-1:0] target_i,
  input  logic          carry_i,
  input  logic          zero_i,
  input  logic          irq_i,
  output logic [AW-1:0] pc_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic          restore_o,
  output logic          int_en_o,
  output logic          stack_err_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [1:0]    sync_q;
  logic          rst_sync_n;
  logic [AW-1:0] pc_q, pc_d, pc_inc, top;
  logic          ie_q, ie_d, sc_q, sc_d, sz_q, sz_d;
  logic          hit, irq_take, push, pop, full, empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  pcseq_cond u_cond (
    .sel_i  (cond_i),
    .carry_i(carry_i),
    .zero_i (zero_i),
    .hit_o  (hit)
  );

  pcseq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(pc_q),
    .top_o  (top),
    .full_o (full),
    .empty_o(empty),
    .err_o  (stack_err_o)
  );

  always_comb begin
    pc_inc    = pc_q + ONE;
    irq_take  = irq_i && ie_q;
    pc_d      = pc_inc;
    ie_d      = ie_q;
    sc_d      = sc_q;
    sz_d      = sz_q;
    push      = 1'b0;
    pop       = 1'b0;
    restore_o = 1'b0;
    if (irq_take) begin
      push = 1'b1;
      pc_d = AW'(VECTOR);
      ie_d = 1'b0;
      sc_d = carry_i;
      sz_d = zero_i;
    end else begin
      case (op_i)
        OP_JUMP: if (hit) pc_d = target_i;
        OP_CALL: if (hit) begin
          push = 1'b1;
          if (!full) pc_d = target_i;
        end
        OP_RET: if (hit) begin
          pop = 1'b1;
          if (!empty) pc_d = top + ONE;
        end
        OP_RETI_EN, OP_RETI_DIS: begin
          pop = 1'b1;
          if (!empty) begin
            pc_d      = top;
            restore_o = 1'b1;
            ie_d      = (op_i == OP_RETI_EN);
          end
        end
        OP_EI:   ie_d = 1'b1;
        OP_DI:   ie_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
      ie_q <= 1'b0;
      sc_q <= 1'b0;
      sz_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      ie_q <= ie_d;
      sc_q <= sc_d;
      sz_q <= sz_d;
    end
  end

  assign pc_o     = pc_q;
  assign int_en_o = ie_q;
  assign carry_o  = sc_q;
  assign zero_o   = sz_q;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op_i,
  input logic [2:0]  cond_i,
  input logic [11:0] target_i,
  input logic        carry_i,
  input logic        zero_i,
  input logic        irq_i,
  input logic [11:0] pc_o,
  input logic        restore_o,
  input logic        int_en_o,
  input logic        stack_err_o
);
  logic quiet;
  assign quiet = !(irq_i && int_en_o);

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 && quiet) |=> pc_o == $past(pc_o) + 12'd1);
  // R3
  a_r3_jump_always: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd1 && !cond_i[2] && quiet) |=> pc_o == $past(target_i));
  // R6
  a_r6_reti_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_o && op_i == 4'd4) |=> int_en_o);
  // R7
  a_r7_ei: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd6 && quiet) |=> int_en_o);
  // R8
  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && int_en_o) |=> (pc_o == 12'hFFF && !int_en_o));
  // R11
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err_o |=> stack_err_o);
  // R6
  a_r6_restore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> (quiet && (op_i == 4'd4 || op_i == 4'd5)));
endmodule

bind pc_sequencer pcseq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .op_i       (op_i),
  .cond_i     (cond_i),
  .target_i   (target_i),
  .carry_i    (carry_i),
  .zero_i     (zero_i),
  .irq_i      (irq_i),
  .pc_o       (pc_o),
  .restore_o  (restore_o),
  .int_en_o   (int_en_o),
  .stack_err_o(stack_err_o)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [2:0]  cond_i = '0;
  logic [11:0] target_i = '0;
  logic        carry_i = 1'b0, zero_i = 1'b0, irq_i = 1'b0;
  logic [11:0] pc_o;
  logic        carry_o, zero_o, restore_o, int_en_o, stack_err_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int m_pc, m_ie, m_c, m_z, m_err;
  int m_stk[$];

  always #2 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .cond_i(cond_i), .target_i(target_i),
    .carry_i(carry_i), .zero_i(zero_i), .irq_i(irq_i), .pc_o(pc_o),
    .carry_o(carry_o), .zero_o(zero_o), .restore_o(restore_o),
    .int_en_o(int_en_o), .stack_err_o(stack_err_o)
  );

  function automatic bit cond_true(int sel, int c, int z);
    case (sel)
      4: return z == 1;
      5: return z == 0;
      6: return c == 1;
      7: return c == 0;
      default: return 1;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "pc_o", int'(pc_o), m_pc);
    check(tag, "int_en_o", int'(int_en_o), m_ie);
    check(tag, "carry_o", int'(carry_o), m_c);
    check(tag, "zero_o", int'(zero_o), m_z);
    check(tag, "stack_err_o", int'(stack_err_o), m_err);
  endtask

  task automatic step(int op, int sel, int tgt, int c, int z, int irq, string tag);
    int nxt;
    int rs;
    op_i = 4'(op); cond_i = 3'(sel); target_i = 12'(tgt);
    carry_i = 1'(c); zero_i = 1'(z); irq_i = 1'(irq);
    #1;
    nxt = (m_pc + 1) % 4096;
    rs = 0;
    if (irq && m_ie == 1) begin
      if (m_stk.size() < 31) m_stk.push_back(m_pc); else m_err = 1;
      m_c = c; m_z = z; m_ie = 0; nxt = 12'hFFF;
    end else begin
      case (op)
        1: if (cond_true(sel, c, z)) nxt = tgt;
        2: if (cond_true(sel, c, z)) begin
             if (m_stk.size() < 31) begin m_stk.push_back(m_pc); nxt = tgt; end
             else m_err = 1;
           end
        3: if (cond_true(sel, c, z)) begin
             if (m_stk.size() > 0) nxt = (m_stk.pop_back() + 1) % 4096;
             else m_err = 1;
           end
        4, 5: begin
             if (m_stk.size() > 0) begin
               nxt = m_stk.pop_back(); rs = 1; m_ie = (op == 4) ? 1 : 0;
             end else m_err = 1;
           end
        6: m_ie = 1;
        7: m_ie = 0;
        default: ;
      endcase
    end
    check(tag, "restore_o", int'(restore_o), rs);
    m_pc = nxt;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    m_pc = 0; m_ie = 0; m_c = 0; m_z = 0; m_err = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    compare_all("R1");

    // R2: plain steps, unused code behaves the same
    step(0, 0, 0, 0, 0, 0, "R2");
    step(9, 0, 12'h123, 0, 0, 0, "R2");
    // R3: each condition taken and not taken
    step(1, 0, 12'h100, 0, 0, 0, "R3");
    step(1, 4, 12'h200, 0, 1, 0, "R3");
    step(1, 4, 12'h300, 0, 0, 0, "R3");
    step(1, 5, 12'h310, 0, 0, 0, "R3");
    step(1, 6, 12'h320, 1, 0, 0, "R3");
    step(1, 6, 12'h330, 0, 0, 0, "R3");
    step(1, 7, 12'h340, 0, 0, 0, "R3");
    step(1, 7, 12'h350, 1, 0, 0, "R3");
    // R2: wrap
    step(1, 0, 12'hFFE, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    // R4/R5: nested calls, conditional skips
    step(2, 0, 12'h400, 0, 0, 0, "R4");
    step(2, 6, 12'h500, 0, 0, 0, "R4");
    step(2, 6, 12'h500, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(2, 5, 12'h600, 0, 0, 0, "R4");
    step(3, 4, 0, 0, 0, 0, "R5");
    step(3, 4, 0, 0, 1, 0, "R5");
    step(3, 7, 0, 0, 0, 0, "R5");
    // R8: interrupt ignored while disabled
    step(0, 0, 0, 1, 1, 1, "R8");
    // R7: enable / disable
    step(6, 0, 0, 0, 0, 0, "R7");
    step(7, 0, 0, 0, 0, 0, "R7");
    step(6, 0, 0, 0, 0, 0, "R7");
    // R8: accept, op discarded
    step(1, 0, 12'h777, 1, 0, 1, "R8");
    step(0, 0, 0, 0, 1, 1, "R8");
    // R6: return with enable, cond ignored
    step(4, 4, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 1, "R8");
    step(5, 6, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, "R8");
    // R5: final return
    step(3, 0, 0, 0, 0, 0, "R5");
    // R9: fill the stack, then overflow
    for (int i = 0; i < 31; i++) step(2, 0, 12'h800 + i, 0, 0, 0, "R9");
    step(2, 0, 12'hABC, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R11");
    step(6, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 1, 1, "R9");
    // drain
    for (int i = 0; i < 31; i++) step(3, 0, 0, 0, 0, 0, "R5");
    // R10: underflow
    step(6, 0, 0, 0, 0, 0, "R10");
    step(3, 0, 0, 0, 0, 0, "R10");
    step(5, 0, 0, 0, 0, 0, "R10");
    step(3, 4, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R11");

    // R10/R11 on a fresh reset
    rst_n = 1'b0;
    @(negedge clk);
    m_pc = 0; m_ie = 0; m_c = 0; m_z = 0; m_err = 0; m_stk.delete();
    compare_all("R11");
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    step(4, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R11");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule